// File: doc/BRIEF.md
# Interrupt Enable, Status and Vector Unit

This block is the interrupt front end of a host-visible register window. Event pulses from the locality arbiter and the data FIFO engine set sticky bits in a status register. Software clears those bits by writing ones to them. An enable register holds one mask bit per source and a master gate at bit 31. One output line signals the host whenever an enabled source is pending.

The electrical form of that line is fixed at build time by a parameter: active-high level, active-low level, rising-edge pulse or falling-edge pulse. A read-only capability word tells software which sources exist, which line form this build uses, and whether the burst count is static.

The window also holds a byte-wide vector register where the host stores the interrupt number it picked. It has a read-only identifier word, with the vendor code in the low half and the device code in the high half, and a revision byte. A vendor code of 0xFFFF tells software that no device is present. Reads are combinational on the read address. Writes are full 32-bit words that take effect at the clock edge.

Top module: `irq_front_unit`

## Requirements
- R1: After reset the enable, status and vector registers read zero, and the line sits at its idle level (0 for active-high level and rising-edge styles, 1 for active-low level and falling-edge styles).
- R2: Source events set status bits whether or not they are enabled. Event inputs 0..3 (data available, status valid, locality changed, command ready) set status bits 0, 1, 2 and 7 at the next clock edge.
- R3: Writing the status register at offset 0x010 clears every source bit written as 1. Bits written as 0 are left unchanged.
- R4: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The line is active only while enable bit 31 is 1 and (status AND enable) over the source bits is non-zero. It follows that condition one clock edge after the registers change.
- R6: In the level styles the line stays active for as long as a contributing status bit remains set. It returns to idle on the edge after the last such bit is cleared.
- R7: In the edge styles the line gives exactly one active cycle each time the masked pending condition goes from false to true. It then stays idle while the condition holds.
- R8: The active level is 1 for the active-high and rising-edge styles and 0 for the active-low and falling-edge styles.
- R9: The enable register at offset 0x008 stores only bits 31, 7, 2, 1 and 0. Its other bits read 0.
- R10: The vector register at offset 0x00C stores the low byte of a write. The upper 24 bits read 0.
- R11: The capability word at offset 0x014 reads 0x087 for the sources. It adds 0x100 when the burst count is static, plus one style bit: 0x008 active-high level, 0x010 active-low level, 0x020 rising edge, 0x040 falling edge.
- R12: Offset 0xF00 reads {device code, vendor code} and offset 0xF04 reads the revision in its low byte. Any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_addr_i | input | 12 | Page offset of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 12 | Page offset of the read |
| rd_data_o | output | 32 | Read data, combinational on rd_addr_i |
| evt_i | input | 4 | Source event pulses: data available, status valid, locality changed, command ready |
| irq_o | output | 1 | Interrupt line in the configured style |

## Verification
The bench drives an event and a clear to the same status bit in one cycle. A design that lets the clear win would lose that interrupt, and the bit would read back 0. Pending sources are left set while the master gate is off. A design that ignored bit 31 would raise the line before software asked for it. A falling-edge instance is held with a source pending for several cycles. A design that mistook level for edge would keep the line low, and a design with the wrong polarity would idle low. The enable register is written with all ones, which exposes any storage of reserved bits, and writes of zero to status show whether clearing is too broad.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;

    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned NUM_SRC = 4;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_VECTOR = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_CAPS   = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_IDENT  = 12'hF00;
    localparam logic [ADDR_W-1:0] OFS_REV    = 12'hF04;

    localparam int unsigned MASTER_BIT = 31;
    localparam logic [DATA_W-1:0] SRC_MASK   = 32'h0000_0087;
    localparam logic [DATA_W-1:0] EN_MASK    = 32'h8000_0087;
    localparam logic [DATA_W-1:0] CAP_STATIC = 32'h0000_0100;

    // line styles: 0 level high, 1 level low, 2 rising edge, 3 falling edge
    localparam int unsigned STYLE_LVL_HI  = 0;
    localparam int unsigned STYLE_LVL_LO  = 1;
    localparam int unsigned STYLE_EDGE_RI = 2;
    localparam int unsigned STYLE_EDGE_FA = 3;

    typedef struct packed {
        logic [DATA_W-1:0] enable;
        logic [DATA_W-1:0] status;
        logic [7:0]        vector;
    } regs_t;

    typedef struct packed {
        logic pend_prev;
        logic line;
    } line_t;

    // status bit position of source event i
    function automatic int unsigned src_pos(input int unsigned i);
        return (i == 3) ? 7 : i;
    endfunction

    function automatic logic [DATA_W-1:0] style_cap(input int unsigned s);
        case (s)
            STYLE_LVL_HI:  return 32'h0000_0008;
            STYLE_LVL_LO:  return 32'h0000_0010;
            STYLE_EDGE_RI: return 32'h0000_0020;
            default:       return 32'h0000_0040;
        endcase
    endfunction

endpackage

// File: rtl/irq_front_regs.sv
module irq_front_regs
    import irq_front_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic [DATA_W-1:0] enable_o,
    output logic [DATA_W-1:0] status_o,
    output logic [7:0]        vector_o
);

    regs_t regs_d, regs_q;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        for (int unsigned i = 0; i < NUM_SRC; i++) begin
            set_vec[src_pos(i)] = evt_i[i];
        end
    end

    always_comb begin
        regs_d  = regs_q;
        clr_vec = '0;
        if (wr_en_i) begin
            case (wr_addr_i)
                OFS_ENABLE: regs_d.enable = wr_data_i & EN_MASK;
                OFS_VECTOR: regs_d.vector = wr_data_i[7:0];
                OFS_STATUS: clr_vec       = wr_data_i & SRC_MASK;
                default:    ;
            endcase
        end
        // a new event outranks a simultaneous clear
        regs_d.status = (regs_q.status & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign enable_o = regs_q.enable;
    assign status_o = regs_q.status;
    assign vector_o = regs_q.vector;

endmodule

// File: rtl/irq_front_line.sv
module irq_front_line
    import irq_front_pkg::*;
#(
    parameter int unsigned LINE_STYLE = STYLE_LVL_HI
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pending_i,
    output logic irq_o
);

    localparam logic IDLE_LVL = (LINE_STYLE == STYLE_LVL_LO) ||
                                (LINE_STYLE == STYLE_EDGE_FA);
    localparam bit   IS_EDGE  = (LINE_STYLE >= STYLE_EDGE_RI);

    line_t line_d, line_q;
    logic  active;

    generate
        if (IS_EDGE) begin : g_edge
            assign active = pending_i & ~line_q.pend_prev;
        end else begin : g_level
            assign active = pending_i;
        end
    endgenerate

    always_comb begin
        line_d           = line_q;
        line_d.pend_prev = pending_i;
        line_d.line      = active ^ IDLE_LVL;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            line_q.pend_prev <= 1'b0;
            line_q.line      <= IDLE_LVL;
        end else begin
            line_q <= line_d;
        end
    end

    assign irq_o = line_q.line;

endmodule

// File: rtl/irq_front_rdmux.sv
module irq_front_rdmux
    import irq_front_pkg::*;
#(
    parameter logic [DATA_W-1:0] CAP_WORD   = '0,
    parameter logic [DATA_W-1:0] IDENT_WORD = '0,
    parameter logic [7:0]        REV_BYTE   = '0
) (
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [DATA_W-1:0] enable_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [7:0]        vector_i,
    output logic [DATA_W-1:0] rd_data_o
);

    always_comb begin
        case (rd_addr_i)
            OFS_ENABLE: rd_data_o = enable_i;
            OFS_VECTOR: rd_data_o = {24'h0, vector_i};
            OFS_STATUS: rd_data_o = status_i;
            OFS_CAPS:   rd_data_o = CAP_WORD;
            OFS_IDENT:  rd_data_o = IDENT_WORD;
            OFS_REV:    rd_data_o = {24'h0, REV_BYTE};
            default:    rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_front_unit.sv
module irq_front_unit
    import irq_front_pkg::*;
#(
    parameter int unsigned LINE_STYLE   = STYLE_LVL_HI,
    parameter bit          BURST_STATIC = 1'b1,
    parameter logic [15:0] VENDOR_CODE  = 16'h1D2C,
    parameter logic [15:0] DEVICE_CODE  = 16'h0B17,
    parameter logic [7:0]  REVISION     = 8'h05
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [11:0]        wr_addr_i,
    input  logic [31:0]        wr_data_i,
    input  logic [11:0]        rd_addr_i,
    output logic [31:0]        rd_data_o,
    input  logic [3:0]         evt_i,
    output logic               irq_o
);

    localparam logic [DATA_W-1:0] CAP_WORD = SRC_MASK | style_cap(LINE_STYLE) |
                                             (BURST_STATIC ? CAP_STATIC : '0);
    localparam logic [DATA_W-1:0] IDENT_WORD = {DEVICE_CODE, VENDOR_CODE};

    logic [DATA_W-1:0] enable_q;
    logic [DATA_W-1:0] status_q;
    logic [7:0]        vector_q;
    logic              pending;

    irq_front_regs u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .evt_i     (evt_i),
        .enable_o  (enable_q),
        .status_o  (status_q),
        .vector_o  (vector_q)
    );

    assign pending = enable_q[MASTER_BIT] && ((status_q & enable_q & SRC_MASK) != '0);

    irq_front_line #(.LINE_STYLE(LINE_STYLE)) u_line (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pending_i (pending),
        .irq_o     (irq_o)
    );

    irq_front_rdmux #(
        .CAP_WORD   (CAP_WORD),
        .IDENT_WORD (IDENT_WORD),
        .REV_BYTE   (REVISION)
    ) u_rdmux (
        .rd_addr_i (rd_addr_i),
        .enable_i  (enable_q),
        .status_i  (status_q),
        .vector_i  (vector_q),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk
    import irq_front_pkg::*;
#(
    parameter int unsigned LINE_STYLE = STYLE_LVL_HI
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        wr_en_i,
    input logic [11:0] wr_addr_i,
    input logic [31:0] wr_data_i,
    input logic [3:0]  evt_i,
    input logic        irq_o,
    input logic [31:0] enable_q,
    input logic [31:0] status_q,
    input logic [7:0]  vector_q
);

    localparam logic IDLE = (LINE_STYLE == STYLE_LVL_LO) || (LINE_STYLE == STYLE_EDGE_FA);
    localparam bit   EDGE = (LINE_STYLE >= STYLE_EDGE_RI);

    logic [31:0] evt_bits;
    assign evt_bits = {24'h0, evt_i[3], 4'h0, evt_i[2:0]};

    logic stat_wr;
    assign stat_wr = wr_en_i && (wr_addr_i == 12'h010);

    // R2
    evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i != 4'h0) |=> ((status_q & $past(evt_bits)) == $past(evt_bits)));

    // R3
    w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_wr |=> ((status_q & $past(wr_data_i) & 32'h87 & ~$past(evt_bits)) == 32'h0));

    // R3
    status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stat_wr && evt_i == 4'h0) |=> $stable(status_q));

    // R5
    master_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_q[31] |=> (irq_o == IDLE));

    // R10
    vector_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == 12'h00C) |=> (vector_q == $past(wr_data_i[7:0])));

    // R7
    edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (EDGE && irq_o != IDLE) |=> (irq_o == IDLE));

endmodule

bind irq_front_unit irq_front_chk #(.LINE_STYLE(LINE_STYLE)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .evt_i     (evt_i),
    .irq_o     (irq_o),
    .enable_q  (enable_q),
    .status_q  (status_q),
    .vector_q  (vector_q)
);

// File: tb/irq_front_unit_test.sv
module irq_front_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data, rd_data_e;
    logic [3:0]  evt = '0;
    logic        irq, irq_e;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_front_unit uut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .evt_i(evt), .irq_o(irq)
    );

    irq_front_unit #(
        .LINE_STYLE(3), .BURST_STATIC(1'b0), .VENDOR_CODE(16'hFFFF),
        .DEVICE_CODE(16'h0000), .REVISION(8'h00)
    ) uut_edge (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data_e),
        .evt_i(evt), .irq_o(irq_e)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d0, output logic [31:0] d1);
        rd_addr = a;
        #1;
        d0 = rd_data;
        d1 = rd_data_e;
    endtask

    task automatic t_reset();
        logic [31:0] a, b;
        rd(12'h008, a, b); check("R1 enable", a, 0);
        rd(12'h010, a, b); check("R1 status", a, 0);
        rd(12'h00C, a, b); check("R1 vector", a, 0);
        check("R1 line level-high idle", {31'h0, irq}, 0);
        check("R8 line falling-edge idle", {31'h0, irq_e}, 1);
    endtask

    task automatic t_ident();
        logic [31:0] a, b;
        rd(12'h014, a, b);
        check("R11 caps level-high static", a, 32'h18F);
        check("R11 caps falling-edge", b, 32'h0C7);
        rd(12'hF00, a, b);
        check("R12 ident", a, 32'h0B17_1D2C);
        check("R12 ident absent", b, 32'h0000_FFFF);
        rd(12'hF04, a, b); check("R12 revision", a, 32'h05);
        rd(12'h020, a, b); check("R12 unmapped", a, 0);
    endtask

    task automatic t_enable_vector();
        logic [31:0] a, b;
        wr(12'h008, 32'hFFFF_FFFF);
        rd(12'h008, a, b); check("R9 enable mask", a, 32'h8000_0087);
        wr(12'h008, 32'h0);
        wr(12'h00C, 32'hABCD_125A);
        rd(12'h00C, a, b); check("R10 vector byte", a, 32'h5A);
    endtask

    task automatic t_level();
        logic [31:0] a, b;
        pulse(4'hF);
        rd(12'h010, a, b); check("R2 all sources set while disabled", a, 32'h87);
        @(negedge clk);
        check("R5 no line when disabled", {31'h0, irq}, 0);
        wr(12'h008, 32'h0000_0087);
        @(negedge clk);
        check("R5 no line without master bit", {31'h0, irq}, 0);
        wr(12'h008, 32'h8000_0001);
        @(negedge clk);
        check("R5 line with master bit", {31'h0, irq}, 1);
        wr(12'h010, 32'h0);
        rd(12'h010, a, b); check("R3 zero write keeps status", a, 32'h87);
        repeat (3) @(negedge clk);
        check("R6 level held", {31'h0, irq}, 1);
        wr(12'h010, 32'h1);
        rd(12'h010, a, b); check("R3 clear bit 0 only", a, 32'h86);
        @(negedge clk);
        check("R6 line drops after clear", {31'h0, irq}, 0);
        wr(12'h010, 32'h87);
        rd(12'h010, a, b); check("R3 clear all", a, 0);
    endtask

    task automatic t_edge();
        wr(12'h008, 32'h8000_0004);
        repeat (2) @(negedge clk);
        check("R8 falling idle before event", {31'h0, irq_e}, 1);
        pulse(4'h4);
        check("R7 no pulse yet", {31'h0, irq_e}, 1);
        @(negedge clk);
        check("R7 R8 low pulse", {31'h0, irq_e}, 0);
        check("R5 level line follows", {31'h0, irq}, 1);
        @(negedge clk);
        check("R7 pulse one cycle", {31'h0, irq_e}, 1);
        repeat (3) @(negedge clk);
        check("R7 no repeat while pending", {31'h0, irq_e}, 1);
        wr(12'h010, 32'h87);
    endtask

    task automatic t_priority();
        logic [31:0] a, b;
        pulse(4'h2);
        rd(12'h010, a, b); check("R2 status-valid sets bit 1", a, 32'h2);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'h010; wr_data = 32'h2; evt = 4'h2;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
        rd(12'h010, a, b); check("R4 set beats clear", a, 32'h2);
        pulse(4'h8);
        rd(12'h010, a, b); check("R2 command-ready bit 7", a, 32'h82);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_enable_vector();
        t_level();
        t_edge();
        t_priority();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule